// File: doc/BRIEF.md
# Interrupt Priority and Entry Sequencer

This block owns the context registers a 32-bit core needs across reset and exception entry: program counter, stack pointer, status word and vector base. After reset it loads the start address and the first stack pointer from the two lowest words of memory. It then collects interrupt requests from two sources. One is an external line that carries a 4-bit level. The other is a single internal peripheral request that is latched with its own 8-bit vector number. The block compares the higher of the two levels with the 4-bit mask field of the status word.

When the core signals an instruction boundary and the pending level is above the mask, the block takes the request. It pushes the status word and then the program counter onto the stack, fetches the handler address from the vector table, and raises the mask to the level it accepted. The core treats `entry_busy` as a hold. The context outputs are final once that flag is low.

Memory traffic uses a single-beat valid/ready channel. A beat is offered on `mem_valid` and completes in the cycle `mem_ready` is high. While `mem_ready` is low the sequencer holds the beat unchanged and does not advance. For a read, `mem_rdata` is taken in the completing cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, the block reads the word at byte address 0 into PC, and then the word at byte address 4 into SP. `entry_busy` stays high from release until both reads have completed.
- R2: Reset sets SR to 0x000000F0 and VBR to 0, and clears any latched internal request. With the mask at 15, no request can be accepted.
- R3: A request is taken only when `insn_boundary` is high, the block is idle, and the effective level (the larger of `ext_lvl` and the latched internal level) is strictly greater than SR[7:4]. A level equal to the mask is not taken.
- R4: A pulse on `int_req` latches `int_lvl` and `int_vec`. The request stays pending, including across entries won by the external source, until it is itself accepted, and then it is cleared. On equal levels the internal source wins.
- R5: When the external source wins, the vector number is `ext_vec` as sampled in the accepting cycle.
- R6: Entry writes the old SR to SP−4 and then the old PC to SP−8, and SP ends 8 lower than at acceptance.
- R7: After both writes, entry reads the word at VBR + 4×vector, and that word becomes the new PC.
- R8: When entry completes, SR[7:4] holds the accepted level and every other SR bit is unchanged.
- R9: `entry_busy` stays high for at least 13 cycles after the accepting edge. With a memory that never stalls it is exactly 13.
- R10: A beat that is not acknowledged keeps `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stable, and the sequence does not advance. With 5 wait states per beat, entry takes 18 cycles.
- R11: `sr_we` and `vbr_we` load SR and VBR only while the block is idle and not accepting in that cycle. At all other times they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | Core is between instructions |
| ext_lvl | input | 4 | External request level, 0 = none |
| ext_vec | input | 8 | Vector number for the external source |
| int_req | input | 1 | One-cycle pulse that latches an internal request |
| int_lvl | input | 4 | Internal request level |
| int_vec | input | 8 | Internal request vector number |
| sr_we | input | 1 | Core write strobe for SR |
| sr_wdata | input | 32 | SR write value |
| vbr_we | input | 1 | Core write strobe for VBR |
| vbr_wdata | input | 32 | VBR write value |
| mem_valid | output | 1 | Memory beat offered |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Beat completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| pc | output | 32 | Program counter |
| sp | output | 32 | Stack pointer |
| sr | output | 32 | Status word |
| vbr | output | 32 | Vector base |
| entry_busy | output | 1 | Reset load or interrupt entry in progress |

## Verification
If the pending latch or the level merge were wrong, the error would show within one boundary strobe. The wrong handler address would appear on the fetch beat and in `pc`, or `entry_busy` would rise or stay low when it should not. A wrong stack step or push order shows on the first two write beats, a few cycles after acceptance. A miscounted latency shows up as a busy window that differs from 13 cycles, or from 18 cycles under stalls. A beat that changes while stalled shows up in the following cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    S_RST_PC  = 3'd0,
    S_RST_SP  = 3'd1,
    S_IDLE    = 3'd2,
    S_PUSH_SR = 3'd3,
    S_PUSH_PC = 3'd4,
    S_FETCH   = 3'd5,
    S_HOLD    = 3'd6
  } seq_st_e;
endpackage

// File: rtl/irq_lvl_merge.sv
module irq_lvl_merge #(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             int_req,
  input  logic [LVL_W-1:0] int_lvl,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             take_int,
  output logic [LVL_W-1:0] eff_lvl,
  output logic [VEC_W-1:0] win_vec,
  output logic             win_int
);
  logic             pend_q;
  logic [LVL_W-1:0] plvl_q;
  logic [VEC_W-1:0] pvec_q;

  // single internal slot; a new pulse overrides a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      plvl_q <= '0;
      pvec_q <= '0;
    end else if (int_req) begin
      pend_q <= 1'b1;
      plvl_q <= int_lvl;
      pvec_q <= int_vec;
    end else if (take_int) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    win_int = pend_q && (plvl_q >= ext_lvl);
    eff_lvl = win_int ? plvl_q : ext_lvl;
    win_vec = win_int ? pvec_q : ext_vec;
  end

  p_int_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take_int |=> pend_q);

  p_eff_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_lvl >= ext_lvl) && (!pend_q || eff_lvl >= plvl_q));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_entry_pkg::*;
#(
  parameter int unsigned LVL_W         = 4,
  parameter int unsigned ENTRY_MIN_CYC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_boundary,
  input  logic [LVL_W-1:0] eff_lvl,
  input  logic [LVL_W-1:0] mask_lvl,
  input  logic             mem_ready,
  output seq_st_e          st,
  output logic             accept,
  output logic             done,
  output logic             beat,
  output logic             mem_valid,
  output logic             mem_we,
  output logic             busy
);
  localparam int unsigned CNT_W = $clog2(ENTRY_MIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_MIN_CYC - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             in_entry;

  assign st        = st_q;
  assign busy      = (st_q != S_IDLE);
  assign mem_valid = (st_q == S_RST_PC) || (st_q == S_RST_SP) ||
                     (st_q == S_PUSH_SR) || (st_q == S_PUSH_PC) ||
                     (st_q == S_FETCH);
  assign mem_we    = (st_q == S_PUSH_SR) || (st_q == S_PUSH_PC);
  assign beat      = mem_valid && mem_ready;
  assign accept    = (st_q == S_IDLE) && insn_boundary && (eff_lvl > mask_lvl);
  assign in_entry  = (st_q == S_PUSH_SR) || (st_q == S_PUSH_PC) ||
                     (st_q == S_FETCH) || (st_q == S_HOLD);
  assign done      = ((st_q == S_FETCH) && beat && (cnt_q >= CNT_LAST)) ||
                     ((st_q == S_HOLD) && (cnt_q >= CNT_LAST));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_RST_PC:  if (beat) st_d = S_RST_SP;
      S_RST_SP:  if (beat) st_d = S_IDLE;
      S_IDLE:    if (accept) st_d = S_PUSH_SR;
      S_PUSH_SR: if (beat) st_d = S_PUSH_PC;
      S_PUSH_PC: if (beat) st_d = S_FETCH;
      S_FETCH:   if (beat) st_d = (cnt_q >= CNT_LAST) ? S_IDLE : S_HOLD;
      S_HOLD:    if (cnt_q >= CNT_LAST) st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_RST_PC;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept)                           cnt_q <= '0;
      else if (in_entry && cnt_q < CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> st_q == $past(st_q));

  p_accept_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && mem_valid && mem_we);
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned DW          = 32,
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned MASK_LSB    = 4,
  parameter int unsigned SR_RESET    = 'hF0,
  parameter int unsigned PC_VEC_ADDR = 0,
  parameter int unsigned SP_VEC_ADDR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_e          st,
  input  logic             beat,
  input  logic             accept,
  input  logic             done,
  input  logic [LVL_W-1:0] acc_lvl,
  input  logic [VEC_W-1:0] acc_vec,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             sr_we,
  input  logic [DW-1:0]    sr_wdata,
  input  logic             vbr_we,
  input  logic [AW-1:0]    vbr_wdata,
  output logic [AW-1:0]    pc,
  output logic [AW-1:0]    sp,
  output logic [DW-1:0]    sr,
  output logic [AW-1:0]    vbr,
  output logic [LVL_W-1:0] mask_lvl,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);
  localparam int unsigned SLOT_B  = DW / 8;
  localparam int unsigned SLOT_SH = $clog2(SLOT_B);

  logic [AW-1:0]    pc_q, sp_q, vbr_q, npc_q;
  logic [DW-1:0]    sr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic [AW-1:0]    sp_dec, vec_addr;
  logic             core_wr_ok;

  assign sp_dec     = sp_q - AW'(SLOT_B);
  assign vec_addr   = vbr_q + (AW'(vec_q) << SLOT_SH);
  assign core_wr_ok = (st == S_IDLE) && !accept;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_RST_PC:  mem_addr = AW'(PC_VEC_ADDR);
      S_RST_SP:  mem_addr = AW'(SP_VEC_ADDR);
      S_PUSH_SR: begin mem_addr = sp_dec; mem_wdata = sr_q; end
      S_PUSH_PC: begin mem_addr = sp_dec; mem_wdata = DW'(pc_q); end
      S_FETCH:   mem_addr = vec_addr;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      sr_q  <= DW'(SR_RESET);
      vbr_q <= '0;
      npc_q <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      if (accept) begin
        lvl_q <= acc_lvl;
        vec_q <= acc_vec;
      end
      if (beat) begin
        unique case (st)
          S_RST_PC:  pc_q  <= AW'(mem_rdata);
          S_RST_SP:  sp_q  <= AW'(mem_rdata);
          S_PUSH_SR: sp_q  <= sp_dec;
          S_PUSH_PC: sp_q  <= sp_dec;
          S_FETCH:   npc_q <= AW'(mem_rdata);
          default:   ;
        endcase
      end
      if (done) begin
        pc_q <= (beat && st == S_FETCH) ? AW'(mem_rdata) : npc_q;
        sr_q[MASK_LSB +: LVL_W] <= lvl_q;
      end
      if (core_wr_ok && sr_we)  sr_q  <= sr_wdata;
      if (core_wr_ok && vbr_we) vbr_q <= vbr_wdata;
    end
  end

  assign pc       = pc_q;
  assign sp       = sp_q;
  assign sr       = sr_q;
  assign vbr      = vbr_q;
  assign mask_lvl = sr_q[MASK_LSB +: LVL_W];

  p_mask_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sr_q[MASK_LSB +: LVL_W] > $past(sr_q[MASK_LSB +: LVL_W]));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !(beat && st == S_RST_PC) |=> $stable(pc_q));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned DW            = 32,
  parameter int unsigned LVL_W         = 4,
  parameter int unsigned VEC_W         = 8,
  parameter int unsigned MASK_LSB      = 4,
  parameter int unsigned ENTRY_MIN_CYC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_boundary,
  input  logic [LVL_W-1:0] ext_lvl,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             int_req,
  input  logic [LVL_W-1:0] int_lvl,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             sr_we,
  input  logic [DW-1:0]    sr_wdata,
  input  logic             vbr_we,
  input  logic [AW-1:0]    vbr_wdata,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    pc,
  output logic [AW-1:0]    sp,
  output logic [DW-1:0]    sr,
  output logic [AW-1:0]    vbr,
  output logic             entry_busy
);
  localparam int unsigned PUSH_BYTES = 2 * (DW / 8);

  seq_st_e          st;
  logic             accept, done, beat, win_int;
  logic [LVL_W-1:0] eff_lvl, mask_lvl;
  logic [VEC_W-1:0] win_vec;

  irq_lvl_merge #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .ext_lvl(ext_lvl), .ext_vec(ext_vec),
    .int_req(int_req), .int_lvl(int_lvl), .int_vec(int_vec),
    .take_int(accept && win_int),
    .eff_lvl(eff_lvl), .win_vec(win_vec), .win_int(win_int)
  );

  irq_seq_fsm #(.LVL_W(LVL_W), .ENTRY_MIN_CYC(ENTRY_MIN_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
    .eff_lvl(eff_lvl), .mask_lvl(mask_lvl), .mem_ready(mem_ready),
    .st(st), .accept(accept), .done(done), .beat(beat),
    .mem_valid(mem_valid), .mem_we(mem_we), .busy(entry_busy)
  );

  irq_ctx_regs #(
    .AW(AW), .DW(DW), .LVL_W(LVL_W), .VEC_W(VEC_W), .MASK_LSB(MASK_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .st(st), .beat(beat), .accept(accept),
    .done(done), .acc_lvl(eff_lvl), .acc_vec(win_vec),
    .mem_rdata(mem_rdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
    .pc(pc), .sp(sp), .sr(sr), .vbr(vbr), .mask_lvl(mask_lvl),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // stack pointer seen at acceptance, for the push-depth check
  logic [AW-1:0] sp_mark_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      sp_mark_q <= '0;
    else if (accept) sp_mark_q <= sp;
  end

  p_sp_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sp == sp_mark_q - AW'(PUSH_BYTES));

  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_boundary = 1'b0;
  logic [3:0]  ext_lvl = '0, int_lvl = '0;
  logic [7:0]  ext_vec = '0, int_vec = '0;
  logic        int_req = 1'b0, sr_we = 1'b0, vbr_we = 1'b0;
  logic [31:0] sr_wdata = '0, vbr_wdata = '0;
  logic        mem_valid, mem_we, mem_ready, entry_busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc, sp, sr, vbr;

  always #2 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
    .ext_lvl(ext_lvl), .ext_vec(ext_vec), .int_req(int_req),
    .int_lvl(int_lvl), .int_vec(int_vec), .sr_we(sr_we),
    .sr_wdata(sr_wdata), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .sr(sr), .vbr(vbr), .entry_busy(entry_busy)
  );

  // memory model with programmable wait states
  logic [31:0] mem [0:255];
  logic [31:0] wl_addr [0:63];
  logic [31:0] wl_data [0:63];
  logic [31:0] rl_addr [0:63];
  int wn = 0, rn = 0, wait_cfg = 0, wcnt = 0;
  int checks = 0, fails = 0;

  assign mem_ready = mem_valid && (wcnt >= wait_cfg);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (mem_valid && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wl_addr[wn % 64] <= mem_addr;
        wl_data[wn % 64] <= mem_wdata;
        wn <= wn + 1;
      end else begin
        rl_addr[rn % 64] <= mem_addr;
        rn <= rn + 1;
      end
    end
  end

  // R10: a stalled beat must reappear unchanged
  logic        prev_stall = 1'b0, prev_we = 1'b0;
  logic [31:0] prev_addr = '0, prev_wd = '0;
  always @(negedge clk) begin
    if (rst_n && prev_stall) begin
      checks++;
      if (!mem_valid || mem_addr !== prev_addr || mem_we !== prev_we ||
          mem_wdata !== prev_wd) begin
        fails++;
        $display("FAIL R10: beat changed while stalled, actual %h expected %h",
                 mem_addr, prev_addr);
      end
    end
    prev_stall = rst_n && mem_valid && !mem_ready;
    prev_addr  = mem_addr;
    prev_we    = mem_we;
    prev_wd    = mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (entry_busy) @(negedge clk);
  endtask

  task automatic write_sr(input logic [31:0] v);
    sr_we = 1'b1; sr_wdata = v; @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic write_vbr(input logic [31:0] v);
    vbr_we = 1'b1; vbr_wdata = v; @(negedge clk); vbr_we = 1'b0;
  endtask

  task automatic strobe_no_accept(input string req);
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0;
    chk(req, {31'd0, entry_busy}, 32'd0);
  endtask

  task automatic run_entry(output int cyc);
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0;
    cyc = 0;
    while (entry_busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    mem[0] = 32'h0000_1000;
    mem[1] = 32'h0000_0400;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy during reset load", {31'd0, entry_busy}, 32'd1);
    wait_idle();
    chk("R1 pc from word 0", pc, 32'h1000);
    chk("R1 sp from word 4", sp, 32'h400);
    chk("R1 first read addr", rl_addr[0], 32'h0);
    chk("R1 second read addr", rl_addr[1], 32'h4);
    chk("R2 sr reset", sr, 32'hF0);
    chk("R2 vbr reset", vbr, 32'h0);
  endtask

  task automatic t_mask_block();
    ext_lvl = 4'd15;
    strobe_no_accept("R2 level 15 blocked by reset mask");
    ext_lvl = 4'd0;
    write_sr(32'h35);
    chk("R11 idle sr write", sr, 32'h35);
  endtask

  task automatic t_ext_entry();
    int c, wb, rb;
    ext_lvl = 4'd3;
    strobe_no_accept("R3 equal level not taken");
    ext_lvl = 4'd5; ext_vec = 8'd9;
    mem[9] = 32'h0000_2000;
    wb = wn; rb = rn;
    run_entry(c);
    ext_lvl = 4'd0;
    chk("R9 entry length zero-wait", c, 13);
    chk("R5 R7 new pc from ext vector", pc, 32'h2000);
    chk("R7 fetch addr", rl_addr[rb % 64], 32'h24);
    chk("R6 sp after entry", sp, 32'h3F8);
    chk("R6 first push addr", wl_addr[wb % 64], 32'h3FC);
    chk("R6 first push data sr", wl_data[wb % 64], 32'h35);
    chk("R6 second push addr", wl_addr[(wb + 1) % 64], 32'h3F8);
    chk("R6 second push data pc", wl_data[(wb + 1) % 64], 32'h1000);
    chk("R8 sr mask raised", sr, 32'h55);
  endtask

  task automatic t_int_entry();
    int c, rb;
    write_vbr(32'h100);
    chk("R11 idle vbr write", vbr, 32'h100);
    write_sr(32'h20);
    int_lvl = 4'd6; int_vec = 8'd3; int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 no entry without boundary", {31'd0, entry_busy}, 32'd0);
    ext_lvl = 4'd6; ext_vec = 8'd7;
    mem[8'h43] = 32'h0000_3000;
    mem[8'h47] = 32'h0000_0BAD;
    rb = rn;
    run_entry(c);
    ext_lvl = 4'd0;
    chk("R4 tie won by internal", pc, 32'h3000);
    chk("R7 fetch addr uses vbr", rl_addr[rb % 64], 32'h10C);
    chk("R8 sr after internal", sr, 32'h60);
    write_sr(32'h0);
    strobe_no_accept("R4 internal cleared after accept");
  endtask

  task automatic t_ext_over_int();
    int c;
    int_lvl = 4'd2; int_vec = 8'd4; int_req = 1'b1;
    @(negedge clk); int_req = 1'b0;
    ext_lvl = 4'd5; ext_vec = 8'd10;
    mem[8'h4A] = 32'h0000_4000;
    mem[8'h44] = 32'h0000_5000;
    run_entry(c);
    ext_lvl = 4'd0;
    chk("R5 higher external wins", pc, 32'h4000);
    chk("R8 sr after external", sr, 32'h50);
    write_sr(32'h10);
    run_entry(c);
    chk("R4 internal still pending", pc, 32'h5000);
    chk("R8 sr after held internal", sr, 32'h20);
  endtask

  task automatic t_wait_states();
    int c;
    wait_cfg = 5;
    write_sr(32'h0F);
    ext_lvl = 4'd1; ext_vec = 8'd2;
    mem[8'h42] = 32'h0000_6000;
    insn_boundary = 1'b1; @(negedge clk); insn_boundary = 1'b0;
    c = 0;
    while (entry_busy) begin
      c++;
      sr_we = (c == 2); sr_wdata = 32'hFFFF_FFFF;
      vbr_we = (c == 2); vbr_wdata = 32'h0;
      @(negedge clk);
    end
    sr_we = 1'b0; vbr_we = 1'b0;
    ext_lvl = 4'd0; wait_cfg = 0;
    chk("R10 entry length with 5 waits", c, 18);
    chk("R10 pc after stalled fetch", pc, 32'h6000);
    chk("R11 R8 sr write ignored while busy", sr, 32'h1F);
    chk("R11 vbr write ignored while busy", vbr, 32'h100);
  endtask

  logic done_flag = 1'b0;

  initial begin
    t_reset();
    t_mask_block();
    t_ext_entry();
    t_int_entry();
    t_ext_over_int();
    t_wait_states();
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule